// File: doc/BRIEF.md
# E1 Transmit Channel-Associated-Signalling Multiframe Generator

This block produces the outgoing bit-serial 2.048 Mb/s primary-rate frame stream. One clock is one line bit. Internal counters walk through the 8 bits of each timeslot, the 32 timeslots of each frame and the 16 frames of each signalling multiframe. Payload bits come from the serial data input. The block overlays the framing and signalling bits on that payload at fixed positions.

Timeslot 0 of every even-numbered frame carries the 7-bit frame alignment pattern. Timeslot 0 of the odd frames passes through the alarm and national bits, except that its second bit is forced to 1. In channel-associated signalling (CAS) mode, timeslot 16 of frame 0 carries the multiframe alignment nibble 0000, followed by four spare bits taken from a static input. Timeslot 16 of frames 1 to 15 carries ABCD signalling, taken either from a dedicated serial signalling input or from the serial data input.

In common-channel (CCS) mode, timeslot 16 passes through untouched. A multiframe sync pulse realigns all counters. Status outputs tell the upstream logic which frame carries alignment, where the multiframe starts, and which channel's signalling is on the line.

Top module: `e1_cas_mf_gen`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after its release, the block sits at bit 1 of timeslot 0 of frame 0. In that state `mf_start`=1, `frm_align`=1, `sig_slot`=0 and `ser_out` equals `ser_in`.
- R2: A frame lasts 256 clocks and a multiframe lasts 4096 clocks. `mf_start` is 1 during all 256 clocks of frame 0 and 0 in every other frame. After frame 15 the count wraps to frame 0.
- R3: `frm_align` is 1 throughout frames 0, 2, 4 … 14 and 0 throughout the odd frames. It flips at every frame boundary.
- R4: In alignment frames, timeslot 0 bits 2 to 8 are 0,0,1,1,0,1,1 in transmit order. Bit 1 passes `ser_in`.
- R5: In odd frames, timeslot 0 bit 2 is driven to 1. Bits 1 and 3 to 8 pass `ser_in`.
- R6: In CAS mode (`ccs_mode`=0), timeslot 16 of frame 0 sends 0,0,0,0 in bits 1 to 4. It then sends `mf_spare[3]`, `mf_spare[2]`, `mf_spare[1]`, `mf_spare[0]` in bits 5 to 8.
- R7: In CAS mode, timeslot 16 of frames 1 to 15 sends `sig_in` when `sig_src_ded`=1 and `ser_in` when `sig_src_ded`=0.
- R8: In CAS mode, during bits 1 to 4 of timeslot 16 of frame n (n=1…15), `sig_slot`=1 and `sig_ch`=n. During bits 5 to 8, `sig_slot`=1 and `sig_ch`=n+16. At every other time, `sig_slot`=0 and `sig_ch`=0.
- R9: In CCS mode (`ccs_mode`=1), timeslot 16 of every frame, including frame 0, passes `ser_in`. `sig_slot` stays 0 and `mf_spare` has no effect.
- R10: When `mf_sync` is 1 at a rising clock edge, the next cycle is bit 1 of timeslot 0 of frame 0, whatever the previous position was.
- R11: Timeslots 1 to 15 and 17 to 31 pass `ser_in` to `ser_out` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mf_sync | input | 1 | Multiframe sync pulse; restarts at frame 0 on the next cycle |
| ser_in | input | 1 | Serial payload and pass-through data |
| sig_in | input | 1 | Dedicated serial signalling input, time-aligned to timeslot 16 |
| sig_src_ded | input | 1 | 1 = signalling from `sig_in`, 0 = from `ser_in` |
| ccs_mode | input | 1 | 0 = CAS overlay in timeslot 16, 1 = CCS pass-through |
| mf_spare | input | 4 | Extra and alarm bits for timeslot 16 of frame 0 |
| ser_out | output | 1 | Outgoing frame stream |
| frm_align | output | 1 | High throughout frames carrying the alignment pattern |
| mf_start | output | 1 | High throughout frame 0 of the multiframe |
| sig_slot | output | 1 | High while CAS signalling bits are on the line |
| sig_ch | output | 5 | Channel whose ABCD bits are currently on the line |

## Verification
The assertions check the following on every cycle:
- the realignment after a sync pulse;
- the flip of the alignment flag at each frame boundary;
- the pass-through of ordinary timeslots and of timeslot 16 in CCS mode;
- the zero nibble of the multiframe alignment word;
- the bounds on the channel indication.

The bench scenarios are needed for the value-specific behaviour: the exact 0011011 pattern, the forced bit in odd frames, the spare-bit order, the choice of signalling source, the n / n+16 channel numbering, and wrap-around at the 4096-clock boundary.

// File: rtl/e1_mf_pkg.sv
// Shared constants and configuration type for the E1 transmit multiframe
// generator. Assumes 8-bit timeslots; the alignment pattern is padded to a
// full byte so that it can be indexed directly by bit position.
package e1_mf_pkg;

    // Frame alignment pattern for bits 2..8, MSB is a pad for bit 1.
    localparam logic [7:0] FAS_BYTE = 8'b1_0011011;

    // Static per-stream configuration.
    typedef struct packed {
        logic       ccs;      // 1 = common-channel, timeslot 16 untouched
        logic       sig_ded;  // 1 = signalling from dedicated input
        logic [3:0] spare;    // extra/alarm bits of multiframe word
    } tx_cfg_t;

endpackage

// File: rtl/e1_tx_counter.sv
// Bit, timeslot and frame position counters. Assumes one clock per line
// bit. A sync pulse forces position zero on the next clock; reset does the
// same. Emits a one-cycle frame_end on the last bit of each frame.
module e1_tx_counter #(
    parameter int TS_BITS   = 8,
    parameter int N_TS      = 32,
    parameter int MF_FRAMES = 16,
    parameter int BIT_W     = $clog2(TS_BITS),
    parameter int TS_W      = $clog2(N_TS),
    parameter int FR_W      = $clog2(MF_FRAMES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync,
    output logic [BIT_W-1:0] bit_idx,
    output logic [TS_W-1:0]  ts_idx,
    output logic [FR_W-1:0]  frm_idx,
    output logic             frame_end
);

    localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(TS_BITS - 1);
    localparam logic [TS_W-1:0]  TS_LAST  = TS_W'(N_TS - 1);
    localparam logic [FR_W-1:0]  FR_LAST  = FR_W'(MF_FRAMES - 1);

    logic bit_wrap;
    logic ts_wrap;

    // Wrap conditions of the two inner counters.
    always_comb begin
        bit_wrap  = (bit_idx == BIT_LAST);
        ts_wrap   = bit_wrap && (ts_idx == TS_LAST);
        frame_end = ts_wrap;
    end

    // Cascaded position counters with sync-to-zero.
    always_ff @(posedge clk) begin
        if (!rst_n || sync) begin
            bit_idx <= '0;
            ts_idx  <= '0;
            frm_idx <= '0;
        end else begin
            bit_idx <= bit_wrap ? '0 : bit_idx + 1'b1;
            if (bit_wrap) begin
                ts_idx <= (ts_idx == TS_LAST) ? '0 : ts_idx + 1'b1;
            end
            if (ts_wrap) begin
                frm_idx <= (frm_idx == FR_LAST) ? '0 : frm_idx + 1'b1;
            end
        end
    end

endmodule

// File: rtl/e1_ts0_insert.sv
// Timeslot 0 overlay. In alignment frames, bits 2..8 carry the fixed
// pattern. In other frames, bit 2 is forced high and the rest pass through.
// Assumes 8-bit timeslots; bit 1 (index 0) always passes through.
module e1_ts0_insert #(
    parameter int TS_BITS = 8,
    parameter int BIT_W   = $clog2(TS_BITS)
) (
    input  logic [BIT_W-1:0] bit_idx,
    input  logic             align_frm,
    input  logic             ser_in,
    output logic             ts0_bit
);

    import e1_mf_pkg::*;

    localparam logic [BIT_W-1:0] TOP_IDX = BIT_W'(TS_BITS - 1);

    logic [BIT_W-1:0] pat_sel;

    // Select pattern bit, or force / pass the non-alignment bit.
    always_comb begin
        pat_sel = TOP_IDX - bit_idx;
        if (bit_idx == '0) begin
            ts0_bit = ser_in;
        end else if (align_frm) begin
            ts0_bit = FAS_BYTE[pat_sel];
        end else if (bit_idx == BIT_W'(1)) begin
            ts0_bit = 1'b1;
        end else begin
            ts0_bit = ser_in;
        end
    end

endmodule

// File: rtl/e1_ts16_cas.sv
// Timeslot 16 overlay. In CAS mode, frame 0 carries a zero nibble and then
// the spare bits; frames 1..15 carry signalling from the selected source,
// with channel n in the first nibble and n+N_TS/2 in the second. In CCS
// mode the slot passes through. Outputs are only meaningful inside slot 16.
module e1_ts16_cas #(
    parameter int TS_BITS   = 8,
    parameter int N_TS      = 32,
    parameter int MF_FRAMES = 16,
    parameter int BIT_W     = $clog2(TS_BITS),
    parameter int TS_W      = $clog2(N_TS),
    parameter int FR_W      = $clog2(MF_FRAMES)
) (
    input  logic                 in_slot,
    input  logic [BIT_W-1:0]     bit_idx,
    input  logic [FR_W-1:0]      frm_idx,
    input  e1_mf_pkg::tx_cfg_t   cfg,
    input  logic                 ser_in,
    input  logic                 sig_in,
    output logic                 ts16_bit,
    output logic                 sig_slot,
    output logic [TS_W-1:0]      sig_ch
);

    localparam int               HALF     = TS_BITS / 2;
    localparam logic [BIT_W-1:0] TOP_IDX  = BIT_W'(TS_BITS - 1);
    localparam logic [TS_W-1:0]  CH_OFFS  = TS_W'(N_TS / 2);

    logic             low_nibble;
    logic [BIT_W-1:0] spare_sel;
    logic             mf_word;

    // Compose the timeslot-16 bit and the signalling channel indication.
    always_comb begin
        low_nibble = (int'(bit_idx) >= HALF);
        spare_sel  = TOP_IDX - bit_idx;
        mf_word    = (frm_idx == '0);
        ts16_bit   = ser_in;
        sig_slot   = 1'b0;
        sig_ch     = '0;
        if (!cfg.ccs) begin
            if (mf_word) begin
                ts16_bit = low_nibble ? cfg.spare[spare_sel[1:0]] : 1'b0;
            end else begin
                ts16_bit = cfg.sig_ded ? sig_in : ser_in;
                sig_slot = in_slot;
                if (in_slot) begin
                    sig_ch = TS_W'(frm_idx) + (low_nibble ? CH_OFFS : '0);
                end
            end
        end
    end

endmodule

// File: rtl/e1_cas_mf_gen.sv
// E1 transmit multiframe generator top. Counts line position, overlays
// timeslot 0 framing and timeslot 16 CAS signalling on the serial stream,
// and flags alignment frames and the multiframe start. Assumes ser_in and
// sig_in are presented in the same cycle as the bit they fill.
module e1_cas_mf_gen #(
    parameter int TS_BITS   = 8,
    parameter int N_TS      = 32,
    parameter int MF_FRAMES = 16,
    parameter int SIG_TS    = 16,
    parameter int BIT_W     = $clog2(TS_BITS),
    parameter int TS_W      = $clog2(N_TS),
    parameter int FR_W      = $clog2(MF_FRAMES)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            mf_sync,
    input  logic            ser_in,
    input  logic            sig_in,
    input  logic            sig_src_ded,
    input  logic            ccs_mode,
    input  logic [3:0]      mf_spare,
    output logic            ser_out,
    output logic            frm_align,
    output logic            mf_start,
    output logic            sig_slot,
    output logic [TS_W-1:0] sig_ch
);

    import e1_mf_pkg::*;

    logic [BIT_W-1:0] bit_idx;
    logic [TS_W-1:0]  ts_idx;
    logic [FR_W-1:0]  frm_idx;
    logic             frame_end;
    logic             in_ts0;
    logic             in_ts16;
    logic             ts0_bit;
    logic             ts16_bit;
    logic             ts16_slot;
    logic [TS_W-1:0]  ts16_ch;
    tx_cfg_t          cfg;

    // Line position counters.
    e1_tx_counter #(
        .TS_BITS(TS_BITS), .N_TS(N_TS), .MF_FRAMES(MF_FRAMES),
        .BIT_W(BIT_W), .TS_W(TS_W), .FR_W(FR_W)
    ) u_cnt (
        .clk(clk), .rst_n(rst_n), .sync(mf_sync),
        .bit_idx(bit_idx), .ts_idx(ts_idx), .frm_idx(frm_idx),
        .frame_end(frame_end)
    );

    // Frame flags and configuration bundling.
    always_comb begin
        frm_align = ~frm_idx[0];
        mf_start  = (frm_idx == '0);
        in_ts0    = (ts_idx == '0);
        in_ts16   = (ts_idx == TS_W'(SIG_TS));
        cfg       = '{ccs: ccs_mode, sig_ded: sig_src_ded, spare: mf_spare};
    end

    // Timeslot 0 framing overlay.
    e1_ts0_insert #(.TS_BITS(TS_BITS), .BIT_W(BIT_W)) u_ts0 (
        .bit_idx(bit_idx), .align_frm(frm_align),
        .ser_in(ser_in), .ts0_bit(ts0_bit)
    );

    // Timeslot 16 signalling overlay.
    e1_ts16_cas #(
        .TS_BITS(TS_BITS), .N_TS(N_TS), .MF_FRAMES(MF_FRAMES),
        .BIT_W(BIT_W), .TS_W(TS_W), .FR_W(FR_W)
    ) u_ts16 (
        .in_slot(in_ts16), .bit_idx(bit_idx), .frm_idx(frm_idx),
        .cfg(cfg), .ser_in(ser_in), .sig_in(sig_in),
        .ts16_bit(ts16_bit), .sig_slot(ts16_slot), .sig_ch(ts16_ch)
    );

    // Output selection by timeslot.
    always_comb begin
        sig_slot = ts16_slot;
        sig_ch   = ts16_ch;
        if (in_ts0) begin
            ser_out = ts0_bit;
        end else if (in_ts16) begin
            ser_out = ts16_bit;
        end else begin
            ser_out = ser_in;
        end
    end

endmodule

// File: rtl/e1_cas_mf_gen_chk.sv
// Property checker for the E1 transmit multiframe generator, bound to the
// top module. Reads the position counters only to find frame boundaries.
module e1_cas_mf_gen_chk #(
    parameter int TS_BITS = 8,
    parameter int N_TS    = 32,
    parameter int SIG_TS  = 16,
    parameter int BIT_W   = $clog2(TS_BITS),
    parameter int TS_W    = $clog2(N_TS)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            mf_sync,
    input logic            ser_in,
    input logic            ccs_mode,
    input logic            ser_out,
    input logic            frm_align,
    input logic            mf_start,
    input logic            sig_slot,
    input logic [TS_W-1:0] sig_ch,
    input logic [BIT_W-1:0] bit_idx,
    input logic [TS_W-1:0]  ts_idx
);

    localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(TS_BITS - 1);
    localparam logic [TS_W-1:0]  TS_LAST  = TS_W'(N_TS - 1);
    localparam logic [TS_W-1:0]  TS_SIG   = TS_W'(SIG_TS);

    // R10
    sync_to_frame0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mf_sync |=> (mf_start && frm_align && bit_idx == '0 && ts_idx == '0));

    // R3
    align_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_idx == BIT_LAST && ts_idx == TS_LAST && !mf_sync)
        |=> (frm_align != $past(frm_align)));

    // R2
    start_is_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mf_start |-> frm_align);

    // R9
    ccs_passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ccs_mode && ts_idx == TS_SIG) |-> (ser_out == ser_in && !sig_slot));

    // R6
    mf_word_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ccs_mode && mf_start && ts_idx == TS_SIG && int'(bit_idx) < TS_BITS / 2)
        |-> !ser_out);

    // R8
    sig_ch_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sig_slot |-> (sig_ch != '0 && ts_idx == TS_SIG && !mf_start));

    // R8
    sig_ch_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sig_slot |-> (sig_ch == '0));

    // R11
    payload_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ts_idx != '0 && ts_idx != TS_SIG) |-> (ser_out == ser_in));

endmodule

bind e1_cas_mf_gen e1_cas_mf_gen_chk #(
    .TS_BITS(TS_BITS), .N_TS(N_TS), .SIG_TS(SIG_TS),
    .BIT_W(BIT_W), .TS_W(TS_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .mf_sync(mf_sync), .ser_in(ser_in),
    .ccs_mode(ccs_mode), .ser_out(ser_out), .frm_align(frm_align),
    .mf_start(mf_start), .sig_slot(sig_slot), .sig_ch(sig_ch),
    .bit_idx(bit_idx), .ts_idx(ts_idx)
);

// File: tb/e1_cas_mf_gen_bench.sv
module e1_cas_mf_gen_bench;

    localparam int MF_LEN = 4096;

    typedef struct packed {
        logic [3:0] fr;
        logic [4:0] ts;
        logic [2:0] bt;
        logic       ccs;
        logic       ded;
        logic       sd;
        logic       sg;
        logic [3:0] spare;
        logic       exp_bit;
        logic [3:0] rq;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VECS [NV] = '{
        '{4'd0,  5'd0,  3'd0, 1'b0, 1'b0, 1'b1, 1'b0, 4'h0, 1'b1, 4'd4},  // R4 bit1 passes
        '{4'd0,  5'd0,  3'd1, 1'b0, 1'b0, 1'b1, 1'b0, 4'h0, 1'b0, 4'd4},  // R4
        '{4'd0,  5'd0,  3'd3, 1'b0, 1'b0, 1'b0, 1'b0, 4'h0, 1'b1, 4'd4},  // R4
        '{4'd0,  5'd0,  3'd5, 1'b0, 1'b0, 1'b1, 1'b0, 4'h0, 1'b0, 4'd4},  // R4
        '{4'd0,  5'd0,  3'd7, 1'b0, 1'b0, 1'b0, 1'b0, 4'h0, 1'b1, 4'd4},  // R4
        '{4'd0,  5'd5,  3'd2, 1'b0, 1'b0, 1'b1, 1'b0, 4'h0, 1'b1, 4'd11}, // R11
        '{4'd0,  5'd16, 3'd0, 1'b0, 1'b0, 1'b1, 1'b0, 4'hA, 1'b0, 4'd6},  // R6
        '{4'd0,  5'd16, 3'd3, 1'b0, 1'b0, 1'b1, 1'b0, 4'hA, 1'b0, 4'd6},  // R6
        '{4'd0,  5'd16, 3'd4, 1'b0, 1'b0, 1'b0, 1'b0, 4'hA, 1'b1, 4'd6},  // R6 spare[3]
        '{4'd0,  5'd16, 3'd5, 1'b0, 1'b0, 1'b1, 1'b0, 4'hA, 1'b0, 4'd6},  // R6 spare[2]
        '{4'd1,  5'd0,  3'd1, 1'b0, 1'b0, 1'b0, 1'b0, 4'h0, 1'b1, 4'd5},  // R5 forced 1
        '{4'd1,  5'd0,  3'd2, 1'b0, 1'b0, 1'b0, 1'b0, 4'h0, 1'b0, 4'd5},  // R5
        '{4'd1,  5'd0,  3'd6, 1'b0, 1'b0, 1'b1, 1'b0, 4'h0, 1'b1, 4'd5},  // R5
        '{4'd1,  5'd16, 3'd0, 1'b0, 1'b1, 1'b0, 1'b1, 4'h0, 1'b1, 4'd7},  // R7 dedicated
        '{4'd1,  5'd16, 3'd6, 1'b0, 1'b0, 1'b0, 1'b1, 4'h0, 1'b0, 4'd7},  // R7 serial
        '{4'd2,  5'd0,  3'd2, 1'b0, 1'b0, 1'b1, 1'b0, 4'h0, 1'b0, 4'd4},  // R4 frame 2
        '{4'd3,  5'd16, 3'd2, 1'b1, 1'b1, 1'b1, 1'b0, 4'h0, 1'b1, 4'd9},  // R9
        '{4'd5,  5'd20, 3'd7, 1'b0, 1'b0, 1'b0, 1'b1, 4'h0, 1'b0, 4'd11}, // R11
        '{4'd15, 5'd16, 3'd7, 1'b0, 1'b1, 1'b1, 1'b0, 4'h0, 1'b0, 4'd7}   // R7
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mf_sync = 1'b0;
    logic       ser_in = 1'b0;
    logic       sig_in = 1'b0;
    logic       sig_src_ded = 1'b0;
    logic       ccs_mode = 1'b0;
    logic [3:0] mf_spare = 4'h0;
    logic       ser_out;
    logic       frm_align;
    logic       mf_start;
    logic       sig_slot;
    logic [4:0] sig_ch;

    int n_chk  = 0;
    int n_fail = 0;
    int bpos   = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    e1_cas_mf_gen u_e1_cas_mf_gen (
        .clk(clk), .rst_n(rst_n), .mf_sync(mf_sync), .ser_in(ser_in),
        .sig_in(sig_in), .sig_src_ded(sig_src_ded), .ccs_mode(ccs_mode),
        .mf_spare(mf_spare), .ser_out(ser_out), .frm_align(frm_align),
        .mf_start(mf_start), .sig_slot(sig_slot), .sig_ch(sig_ch)
    );

    task automatic check(input string tag, input int act, input int exp_v);
        n_chk++;
        if (act != exp_v) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d (pos %0d)", tag, act, exp_v, bpos);
        end
    endtask

    // One bit clock; bench position follows R2/R10 independently.
    task automatic tick();
        @(posedge clk);
        bpos = mf_sync ? 0 : (bpos + 1) % MF_LEN;
        @(negedge clk);
        #1;
    endtask

    task automatic advance_to(input int target);
        while (bpos != target) tick();
    endtask

    // Watchdog: an expired run counts as a failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        ser_in = 1'b1;
        #1;
        check("R1 mf_start in reset", int'(mf_start), 1);
        check("R1 frm_align in reset", int'(frm_align), 1);
        check("R1 sig_slot in reset", int'(sig_slot), 0);
        check("R1 ser_out bit1", int'(ser_out), 1);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        bpos = 0;
        check("R1 mf_start after release", int'(mf_start), 1);
        ser_in = 1'b0;
        #1;
        check("R1 ser_out after release", int'(ser_out), 0);

        // Vector table walk.
        for (int i = 0; i < NV; i++) begin
            advance_to(int'(VECS[i].fr) * 256 + int'(VECS[i].ts) * 8 + int'(VECS[i].bt));
            ccs_mode    = VECS[i].ccs;
            sig_src_ded = VECS[i].ded;
            ser_in      = VECS[i].sd;
            sig_in      = VECS[i].sg;
            mf_spare    = VECS[i].spare;
            #1;
            check($sformatf("R%0d vector %0d ser_out", VECS[i].rq, i),
                  int'(ser_out), int'(VECS[i].exp_bit));
        end
        ccs_mode = 1'b0;
        sig_src_ded = 1'b0;

        // R2: multiframe wrap
        advance_to(4095);
        check("R2 mf_start in frame 15", int'(mf_start), 0);
        advance_to(0);
        check("R2 mf_start after wrap", int'(mf_start), 1);

        // R9: CCS frame 0 slot 16 ignores spare bits
        ccs_mode = 1'b1;
        mf_spare = 4'h0;
        ser_in   = 1'b1;
        advance_to(128);
        check("R9 ccs frame0 ser_out", int'(ser_out), 1);
        check("R9 ccs sig_slot", int'(sig_slot), 0);
        mf_spare = 4'hF;
        ser_in   = 1'b0;
        advance_to(132);
        check("R9 ccs spare ignored", int'(ser_out), 0);
        ccs_mode = 1'b0;

        // R3: alignment flag alternates
        advance_to(255);
        check("R3 frm_align frame 0 end", int'(frm_align), 1);
        advance_to(256);
        check("R3 frm_align frame 1", int'(frm_align), 0);
        check("R2 mf_start frame 1", int'(mf_start), 0);
        advance_to(512);
        check("R3 frm_align frame 2", int'(frm_align), 1);

        // R8: channel indication in frame 3
        advance_to(896);
        check("R8 sig_slot upper nibble", int'(sig_slot), 1);
        check("R8 sig_ch upper nibble", int'(sig_ch), 3);
        advance_to(900);
        check("R8 sig_ch lower nibble", int'(sig_ch), 19);
        advance_to(904);
        check("R8 sig_slot after slot", int'(sig_slot), 0);
        check("R8 sig_ch after slot", int'(sig_ch), 0);

        // R10: sync from the middle of an odd frame
        advance_to(1000);
        check("R10 pre-sync frame", int'(frm_align), 0);
        mf_sync = 1'b1;
        tick();
        mf_sync = 1'b0;
        #1;
        check("R10 mf_start after sync", int'(mf_start), 1);
        check("R10 frm_align after sync", int'(frm_align), 1);
        ser_in = 1'b1;
        tick();
        check("R10 pattern bit2 after sync", int'(ser_out), 0);
        ser_in = 1'b0;
        tick();
        tick();
        check("R10 pattern bit4 after sync", int'(ser_out), 1);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule